// File: doc/BRIEF.md
# Station-Management Serial Master (MDC/MDIO)

This block is the management-port master for external PHYs. It divides the core clock down to a management clock (MDC), serialises one management frame at a time onto a bidirectional data line (split here into `mdio_out`, `mdio_oe` and `mdio_in`), and, for frames that return data, captures the 16 bits that the PHY drives back. Software works it through a five-word register window. It writes timing and format settings and the enable, then writes a command word. Completion is learned by polling per-direction pending and valid flags.

Both frame families are supported: the short-address format (start code 01, two opcodes) and the extended-address format (start code 00, four opcodes). The core-clock instant at which returned data is captured is programmable. It can be counted from the falling MDC edge on which the PHY launches a bit, or from the rising edge that follows it. The 32-bit preamble is optional, and MDC can be made to stand still while no frame is in flight.

The frame engine is a state machine with states IDLE, ARM, PREAMBLE, HEADER, TURN and DATA. A command that is accepted takes IDLE to ARM. Every later transition happens on a falling MDC edge. ARM goes to PREAMBLE when the preamble is enabled and to HEADER when it is not. PREAMBLE goes to HEADER after 32 ones. HEADER goes to TURN after 14 bits: start code, opcode, port address and register/device address. TURN goes to DATA after 2 bits. DATA returns to IDLE on the falling edge that ends the 16th data bit, and the completion flags update on that same edge.

Top module: `mdio_master`

## Requirements
- R1: Register offsets on `reg_addr`: 0 config, 1 enable, 2 command, 3 write data/status, 4 read data/status. Config bits: [7:0] PHASE, [16:8] sample count SCNT, [17] reference select LREF, [18] preamble enable, [19] idle-quiet, [20] extended format. Reset value is 0x4040A (PHASE 10, SCNT 4, preamble on). Enable is bit 0 and resets to 0. While running, every MDC high and low phase lasts exactly PHASE core cycles (PHASE > 2).
- R2: Command word bits: [4:0] register/device address, [9:5] port address, [11:10] opcode. In the short format, opcode 0 is a write and is sent as wire opcode 01. A write frame, MSB first, is start 01, opcode, port, register, turnaround 10 and the 16 bits of write data. MDIO changes only on falling MDC edges.
- R3: In the short format, opcode 1 is a read and is sent as 10. The master drives through the address fields, releases the line (`mdio_oe` = 0) for both turnaround bits and all 16 data bits, and returns the 16 captured bits, MSB first, in read-data bits [15:0].
- R4: In the extended format the start code is 00 and the wire opcode equals the command opcode: 00 address, 01 write, 10 post-read-increment-address, 11 read. Opcodes 2 and 3 are read-type and opcodes 0 and 1 are write-type.
- R5: With the preamble enabled, 32 driven ones come before the start code. With it disabled, the frame begins directly with the start code.
- R6: Read data is captured SCNT core cycles after the reference edge. With LREF = 1 the reference is the falling MDC edge that launched the bit. With LREF = 0 it is the next rising edge. SCNT must exceed 1, and must be below PHASE when LREF = 0.
- R7: With idle-quiet set, MDC does not move while no frame is in flight. With it clear, MDC keeps toggling while idle.
- R8: With enable at 0, MDC does not move, and a command write starts no frame and leaves no pending flag.
- R9: Status words hold data in [15:0], valid in [16] and pending in [17]. Pending is set from the accepted command until completion. On completion, pending clears in the same cycle that valid sets. A read of the status word clears its valid flag. Write-type frames report through offset 3 and read-type frames through offset 4.
- R10: A command write that arrives while a frame is pending is ignored. The wire frame and the command read-back both stay those of the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears valid flags on status words) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line value seen at the pad |

## Verification
The bench keeps the default parameters: an 8-bit phase field, a 9-bit sample count, 5-bit addresses, 16-bit data and a 32-bit preamble. It drives the runtime fields to their edges: PHASE at its minimum of 3 and at 4 and 5, SCNT at its minimum of 2, and both reference edges. Together these reach the tightest legal sample windows. The bench's PHY model drives the correct data bit only within one cycle of the expected capture instant and drives the inverted bit at every other time, so a capture that happens at the wrong time or from the wrong reference edge shows up as wrong read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    localparam logic [2:0] OFS_CFG  = 3'd0;
    localparam logic [2:0] OFS_EN   = 3'd1;
    localparam logic [2:0] OFS_CMD  = 3'd2;
    localparam logic [2:0] OFS_WDAT = 3'd3;
    localparam logic [2:0] OFS_RDAT = 3'd4;

    // Wire opcode: short format maps 0->01, 1->10; extended format passes through.
    function automatic logic [1:0] wire_op(input logic ext, input logic [1:0] op);
        if (ext) return op;
        return op[0] ? 2'b10 : 2'b01;
    endfunction

    // Frames whose data phase is driven by the PHY.
    function automatic logic read_type(input logic ext, input logic [1:0] op);
        return ext ? op[1] : op[0];
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PHASE_W-1:0] phase,
    output logic               mdc,
    output logic               rise_evt,
    output logic               fall_evt
);
    logic [PHASE_W-1:0] cnt_q;
    logic               at_end;

    assign at_end   = (cnt_q >= phase - 1'b1);
    assign rise_evt = run && at_end && !mdc;
    assign fall_evt = run && at_end && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: a legal phase never yields back-to-back MDC edges
    p_min_half_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase > 2 && mdc != $past(mdc)) |=> $stable(mdc));

endmodule

// File: rtl/mdio_sampler.sv
module mdio_sampler #(
    parameter int SCNT_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              launch_ref,
    input  logic [SCNT_W-1:0] scnt,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_in,
    output logic [DATA_W-1:0] shift_q
);
    logic [SCNT_W-1:0] timer_q;
    logic              ref_evt;
    logic              capture;

    assign ref_evt = active && (launch_ref ? fall_evt : rise_evt);
    assign capture = (timer_q == SCNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            shift_q <= '0;
        end else begin
            if (ref_evt)
                timer_q <= scnt;
            else if (timer_q != '0)
                timer_q <= timer_q - 1'b1;
            if (capture)
                shift_q <= {shift_q[DATA_W-2:0], mdio_in};
        end
    end

    // R6: a capture never coincides with a fresh reference edge on legal settings
    p_capture_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_evt && scnt > 1) |=> !capture);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext,
    input  logic              pre_en,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] port,
    input  logic [ADDR_W-1:0] dev,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fall_evt,
    output logic              busy,
    output logic              done,
    output logic              rd_frame,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int HDR_W   = 4 + 2 * ADDR_W;
    localparam int FRAME_W = HDR_W + 2 + DATA_W;
    localparam int MAXLEN  = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int CNT_W   = $clog2(MAXLEN);

    frame_state_e       st_q, st_d;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               last;

    assign last     = (cnt_q == '0);
    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_DATA) && fall_evt && last;

    // next-state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ARM;
            ST_ARM:  if (fall_evt) st_d = pre_en ? ST_PRE : ST_HDR;
            ST_PRE:  if (fall_evt && last) st_d = ST_HDR;
            ST_HDR:  if (fall_evt && last) st_d = ST_TURN;
            ST_TURN: if (fall_evt && last) st_d = ST_DATA;
            ST_DATA: if (fall_evt && last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            rd_frame <= 1'b0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
        end else if (st_q == ST_IDLE) begin
            if (start) begin
                rd_frame <= read_type(ext, op);
                sh_q     <= {ext ? 2'b00 : 2'b01, wire_op(ext, op), port, dev,
                             read_type(ext, op) ? 2'b11 : 2'b10, wdata};
            end
        end else if (fall_evt) begin
            unique case (st_q)
                ST_ARM: begin
                    mdio_oe <= 1'b1;
                    if (pre_en) begin
                        mdio_out <= 1'b1;
                        cnt_q    <= CNT_W'(PRE_LEN - 1);
                    end else begin
                        mdio_out <= sh_q[FRAME_W-1];
                        sh_q     <= sh_q << 1;
                        cnt_q    <= CNT_W'(HDR_W - 1);
                    end
                end
                ST_PRE: begin
                    if (last) begin
                        mdio_out <= sh_q[FRAME_W-1];
                        sh_q     <= sh_q << 1;
                        cnt_q    <= CNT_W'(HDR_W - 1);
                    end else begin
                        mdio_out <= 1'b1;
                        cnt_q    <= cnt_q - 1'b1;
                    end
                end
                ST_HDR, ST_TURN: begin
                    mdio_out <= sh_q[FRAME_W-1];
                    sh_q     <= sh_q << 1;
                    if (last) begin
                        mdio_oe <= !rd_frame;
                        cnt_q   <= (st_q == ST_HDR) ? CNT_W'(1) : CNT_W'(DATA_W - 1);
                    end else begin
                        cnt_q   <= cnt_q - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (last) begin
                        mdio_oe  <= 1'b0;
                        mdio_out <= 1'b1;
                    end else begin
                        mdio_out <= sh_q[FRAME_W-1];
                        sh_q     <= sh_q << 1;
                        cnt_q    <= cnt_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: line stays released through the data phase of a read-type frame
    p_read_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && rd_frame) |-> !mdio_oe);

    // R5: preamble bits are driven ones
    p_preamble_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRE) |-> (mdio_out && mdio_oe));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int SCNT_W  = 9,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32,
    parameter int REG_DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    localparam int CFG_W     = PHASE_W + SCNT_W + 4;
    localparam int CMD_W     = 2 * ADDR_W + 2;
    localparam int LREF_BIT  = PHASE_W + SCNT_W;
    localparam int PRE_BIT   = LREF_BIT + 1;
    localparam int QUIET_BIT = LREF_BIT + 2;
    localparam int EXT_BIT   = LREF_BIT + 3;
    localparam logic [CFG_W-1:0] CFG_RST =
        CFG_W'(10) | (CFG_W'(4) << PHASE_W) | (CFG_W'(1) << PRE_BIT);

    logic [CFG_W-1:0]  cfg_q;
    logic              en_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] wdat_q, rdat_q;
    logic              pend_wr, val_wr, pend_rd, val_rd;

    logic              busy, done, rd_frame, rise_evt, fall_evt, run;
    logic              cmd_wr, accept, new_rd;
    logic [DATA_W-1:0] shift_q;

    assign cmd_wr = reg_wr && (reg_addr == OFS_CMD);
    assign accept = cmd_wr && en_q && !busy && !pend_wr && !pend_rd;
    assign new_rd = read_type(cfg_q[EXT_BIT], reg_wdata[2*ADDR_W +: 2]);
    assign run    = en_q && (busy || !cfg_q[QUIET_BIT]);

    mdio_clkgen #(.PHASE_W(PHASE_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .phase(cfg_q[PHASE_W-1:0]),
        .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    mdio_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .ext(cfg_q[EXT_BIT]), .pre_en(cfg_q[PRE_BIT]),
        .op(reg_wdata[2*ADDR_W +: 2]), .port(reg_wdata[ADDR_W +: ADDR_W]),
        .dev(reg_wdata[ADDR_W-1:0]), .wdata(wdat_q), .fall_evt(fall_evt),
        .busy(busy), .done(done), .rd_frame(rd_frame),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe)
    );

    mdio_sampler #(.SCNT_W(SCNT_W), .DATA_W(DATA_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .active(busy), .launch_ref(cfg_q[LREF_BIT]),
        .scnt(cfg_q[PHASE_W +: SCNT_W]), .rise_evt(rise_evt), .fall_evt(fall_evt),
        .mdio_in(mdio_in), .shift_q(shift_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= CFG_RST;
            en_q    <= 1'b0;
            cmd_q   <= '0;
            wdat_q  <= '0;
            rdat_q  <= '0;
            pend_wr <= 1'b0;
            val_wr  <= 1'b0;
            pend_rd <= 1'b0;
            val_rd  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFS_CFG)  cfg_q  <= reg_wdata[CFG_W-1:0];
            if (reg_wr && reg_addr == OFS_EN)   en_q   <= reg_wdata[0];
            if (reg_wr && reg_addr == OFS_WDAT) wdat_q <= reg_wdata[DATA_W-1:0];
            if (reg_rd && reg_addr == OFS_WDAT) val_wr <= 1'b0;
            if (reg_rd && reg_addr == OFS_RDAT) val_rd <= 1'b0;
            if (accept) begin
                cmd_q <= reg_wdata[CMD_W-1:0];
                if (new_rd) pend_rd <= 1'b1;
                else        pend_wr <= 1'b1;
            end
            if (done) begin
                if (rd_frame) begin
                    pend_rd <= 1'b0;
                    val_rd  <= 1'b1;
                    rdat_q  <= shift_q;
                end else begin
                    pend_wr <= 1'b0;
                    val_wr  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CFG:  reg_rdata = REG_DW'(cfg_q);
            OFS_EN:   reg_rdata = REG_DW'(en_q);
            OFS_CMD:  reg_rdata = REG_DW'(cmd_q);
            OFS_WDAT: reg_rdata = REG_DW'({pend_wr, val_wr, wdat_q});
            OFS_RDAT: reg_rdata = REG_DW'({pend_rd, val_rd, rdat_q});
            default:  reg_rdata = '0;
        endcase
    end

    // R9: at most one direction is in flight
    p_one_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pend_wr, pend_rd}));
    // R9: read pending drops only together with valid rising
    p_read_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_rd) |-> val_rd);
    // R10: command register frozen while a frame is in flight
    p_cmd_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(cmd_q));
    // R8: disabled interface keeps MDC still
    p_disabled_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(mdc));
    // R7: idle-quiet keeps MDC still between frames
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[QUIET_BIT] && !busy) |=> $stable(mdc));

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int tests = 0, fails = 0;
    bit finished = 0;

    logic [1:0]  sbq[$];   // expected wire items {oe, value}
    logic [15:0] rq[$];    // expected read data
    string       cur_tag = "R2";

    int          exp_phase = 10;
    int          exp_s = 2;
    logic [15:0] phy_word = '0;
    bit          phy_rd = 0;
    int          mdc_moves = 0;

    always #2 clk = !clk;   // 250 MHz

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(int ph, int sc, bit lref, bit pre, bit quiet, bit ext);
        return 32'(ph) | (32'(sc) << 8) | (32'(lref) << 17) | (32'(pre) << 18)
             | (32'(quiet) << 19) | (32'(ext) << 20);
    endfunction

    function automatic logic [31:0] mk_cmd(logic [1:0] op, logic [4:0] port, logic [4:0] dev);
        return 32'(dev) | (32'(port) << 5) | (32'(op) << 10);
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic set_cfg(int ph, int sc, bit lref, bit pre, bit quiet, bit ext);
        exp_phase = ph;
        exp_s = lref ? sc : ph + sc;
        wr_reg(3'd0, mk_cfg(ph, sc, lref, pre, quiet, ext));
    endtask

    // driver: push expected wire items
    task automatic push_frame(bit ext, bit pre, logic [1:0] op, logic [4:0] port,
                              logic [4:0] dev, logic [15:0] data, bit is_rd);
        logic [1:0] wop;
        wop = ext ? op : (op[0] ? 2'b10 : 2'b01);
        if (pre) for (int i = 0; i < 32; i++) sbq.push_back(2'b11);
        sbq.push_back({1'b1, 1'b0});
        sbq.push_back({1'b1, !ext});
        for (int i = 1; i >= 0; i--) sbq.push_back({1'b1, wop[i]});
        for (int i = 4; i >= 0; i--) sbq.push_back({1'b1, port[i]});
        for (int i = 4; i >= 0; i--) sbq.push_back({1'b1, dev[i]});
        if (is_rd) begin
            for (int i = 0; i < 18; i++) sbq.push_back(2'b00);
        end else begin
            sbq.push_back(2'b11);
            sbq.push_back(2'b10);
            for (int i = 15; i >= 0; i--) sbq.push_back({1'b1, data[i]});
        end
    endtask

    task automatic run_frame(bit ext, bit pre, logic [1:0] op, logic [4:0] port,
                             logic [4:0] dev, logic [15:0] data, string tag);
        bit is_rd;
        logic [2:0] sa;
        logic [31:0] v;
        bit got;
        is_rd = ext ? op[1] : op[0];
        sa = is_rd ? 3'd4 : 3'd3;
        cur_tag = tag;
        push_frame(ext, pre, op, port, dev, data, is_rd);
        phy_rd = is_rd;
        if (is_rd) begin phy_word = data; rq.push_back(data); end
        else wr_reg(3'd3, 32'(data));
        wr_reg(3'd2, mk_cmd(op, port, dev));
        rd_reg(sa, v);
        chk(v[17] && !v[16], {tag, " R9 pending during frame"}, v[17:16], 2'b10);
        got = 0;
        for (int k = 0; k < 3000 && !got; k++) begin
            rd_reg(sa, v);
            got = v[16];
        end
        chk(got && !v[17], {tag, " R9 valid with pending clear"}, v[17:16], 2'b01);
        if (is_rd && rq.size() > 0) begin
            logic [15:0] e;
            e = rq.pop_front();
            chk(v[15:0] == e, {tag, " R3 read data"}, v[15:0], e);
        end
        rd_reg(sa, v);
        chk(!v[16], {tag, " R9 read clears valid"}, v[16], 0);
        chk(sbq.size() == 0, {tag, " all wire bits seen"}, sbq.size(), 0);
        sbq.delete();
    endtask

    // monitor and PHY model
    logic prev_mdc = 1'b0, prev_oe = 1'b0;
    bit   active = 0, in_rd = 0;
    int   run_len = 0, since_fall = 0, dfall = 0;

    always @(negedge clk) begin
        logic [1:0] it;
        bit fell, rose, bitv;
        fell = prev_mdc && !mdc;
        rose = !prev_mdc && mdc;
        if (fell || rose) begin
            mdc_moves++;
            if (active)
                chk(run_len + 1 == exp_phase, "R1 half period", run_len + 1, exp_phase);
            run_len = 0;
        end else run_len++;
        since_fall = fell ? 0 : since_fall + 1;
        if (mdio_oe && !prev_oe) active = 1;
        if (active && rose) begin
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                if (it[1])
                    chk(mdio_oe && mdio_out == it[0], {cur_tag, " wire bit"}, {mdio_oe, mdio_out}, it);
                else
                    chk(!mdio_oe, {cur_tag, " R3 line released"}, mdio_oe, 0);
            end
            if (sbq.size() == 0) active = 0;
        end
        if (active && phy_rd && prev_oe && !mdio_oe) begin
            in_rd = 1; dfall = 0;
        end else if (in_rd && fell) begin
            dfall++;
            if (dfall >= 18) in_rd = 0;
        end
        if (in_rd && dfall >= 2) begin
            bitv = phy_word[17 - dfall];
            mdio_in = (since_fall >= exp_s - 2 && since_fall <= exp_s) ? bitv : !bitv;
        end else if (in_rd && dfall == 1) mdio_in = 1'b0;
        else mdio_in = 1'b1;
        prev_mdc = mdc;
        prev_oe  = mdio_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int m0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(mdc == 0 && mdio_oe == 0, "R1 reset pins", {mdc, mdio_oe}, 0);
        rd_reg(3'd0, v); chk(v == 32'h4040A, "R1 config reset", v, 32'h4040A);
        rd_reg(3'd1, v); chk(v == 0, "R1 enable reset", v, 0);
        rd_reg(3'd4, v); chk(v == 0, "R9 read status reset", v, 0);

        // R8: disabled, command ignored, MDC still
        m0 = mdc_moves;
        wr_reg(3'd2, mk_cmd(2'd0, 5'd3, 5'd4));
        repeat (80) @(negedge clk);
        chk(mdc_moves == m0, "R8 mdc still when disabled", mdc_moves - m0, 0);
        rd_reg(3'd3, v); chk(v[17] == 0, "R8 no pending when disabled", v[17], 0);
        rd_reg(3'd2, v); chk(v == 0, "R8 command not taken", v, 0);

        // R7: free-running idle clock, then R8 stop, then quiet
        set_cfg(4, 2, 1, 1, 0, 0);
        wr_reg(3'd1, 1);
        m0 = mdc_moves;
        repeat (60) @(negedge clk);
        chk(mdc_moves > m0, "R7 idle toggling", mdc_moves - m0, 1);
        wr_reg(3'd1, 0);
        @(negedge clk);
        m0 = mdc_moves;
        repeat (60) @(negedge clk);
        chk(mdc_moves == m0, "R8 disable freezes mdc", mdc_moves - m0, 0);
        set_cfg(4, 3, 1, 1, 1, 0);
        wr_reg(3'd1, 1);
        m0 = mdc_moves;
        repeat (60) @(negedge clk);
        chk(mdc_moves == m0, "R7 quiet idle", mdc_moves - m0, 0);

        // R2 short-format write with preamble
        run_frame(0, 1, 2'd0, 5'h15, 5'h0A, 16'hA5C3, "R2");
        // R3 short-format read, launch-edge reference
        run_frame(0, 1, 2'd1, 5'h01, 5'h1F, 16'hBEEF, "R3");
        // R6 rising-edge reference
        set_cfg(5, 2, 0, 1, 1, 0);
        run_frame(0, 1, 2'd1, 5'h1E, 5'h02, 16'h6C39, "R6");
        // R5 no preamble, minimum phase, idle clock running
        set_cfg(3, 2, 1, 0, 0, 0);
        run_frame(0, 0, 2'd0, 5'h0F, 5'h11, 16'h0FF0, "R5");
        run_frame(0, 0, 2'd1, 5'h10, 5'h05, 16'h8001, "R5");
        // R4 extended format, all four opcodes
        set_cfg(3, 2, 1, 1, 1, 1);
        run_frame(1, 1, 2'd0, 5'h07, 5'h01, 16'h1234, "R4");
        run_frame(1, 1, 2'd1, 5'h07, 5'h01, 16'hFEDC, "R4");
        run_frame(1, 1, 2'd2, 5'h07, 5'h03, 16'h5A5A, "R4");
        run_frame(1, 1, 2'd3, 5'h1B, 5'h1E, 16'h00FF, "R4");

        // R10 second command during a pending frame
        set_cfg(3, 2, 1, 0, 1, 0);
        cur_tag = "R10";
        push_frame(0, 0, 2'd0, 5'h0C, 5'h03, 16'h3C3C, 0);
        phy_rd = 0;
        wr_reg(3'd3, 32'h3C3C);
        wr_reg(3'd2, mk_cmd(2'd0, 5'h0C, 5'h03));
        wr_reg(3'd2, mk_cmd(2'd1, 5'h11, 5'h12));
        begin
            bit got;
            got = 0;
            for (int k = 0; k < 3000 && !got; k++) begin
                rd_reg(3'd3, v);
                got = v[16];
            end
            chk(got, "R10 first frame completes", v[16], 1);
        end
        rd_reg(3'd4, v); chk(v[17:16] == 0, "R10 no read frame started", v[17:16], 0);
        rd_reg(3'd2, v);
        chk(v == mk_cmd(2'd0, 5'h0C, 5'h03), "R10 command kept", v, mk_cmd(2'd0, 5'h0C, 5'h03));
        chk(sbq.size() == 0, "R10 wire frame of first command", sbq.size(), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule